// File: doc/BRIEF.md
# Indexed Vector Remap Unit

This block sits beside a vector loop sequencer. A configuration command loads an index-table base, a five-bit operand enable mask, a dimension size and a 2D-order flag. From that command the block derives the shape-slot routing for each operand. It also computes, once, the size of the second dimension.

After configuration, the sequencer presents one request per element step. Each request gives an operand number, the loop step and the operand's base register. For an enabled operand, the block works out which table entry the step maps to and fetches that entry through a valid/ready register-file read port. It then adds the entry's low bits to the base register and returns the sum. For an operand whose mask bit is clear, it returns the plain sequential number, base plus step.

Top module: `idx_remap_unit`

## Requirements
- R1: A configuration sets the table base of every shape slot that the mask occupies to twice the encoded base field. Slot s is occupied when s is less than the number of set mask bits. Unoccupied slots report a base of 0. Slot s is carried in `slot_base[5*s+4:5*s]`.
- R2: `remap_en` equals the configured 5-bit mask without change.
- R3: Mask bits 0, 1 and 2 enable input operands 0, 1 and 2. Bits 3 and 4 enable output operands 3 and 4. An enabled operand k is given a slot number equal to the count of set mask bits below bit k. An operand with a clear bit reads slot 0. The slot of operand k is in `slot_sel[2*k+1:2*k]`.
- R4: With the 2D flag clear and dimension D, step i reads register (table base + (i mod D)) mod 32.
- R5: With the 2D flag set, step i reads entry (i div D) + (i mod D)·Y, where Y = VL div D is fixed at configuration.
- R6: A configured dimension of 0 behaves exactly as a dimension of 1.
- R7: For an operand whose mask bit is clear, the result is (base + step) mod 32. It appears on the cycle after the request is accepted, and no read is issued.
- R8: `rd_valid` stays high with a stable `rd_addr` until `rd_ready` is seen. The result appears exactly one cycle after `rd_rvalid`, and equals (base + low 5 bits of the read data) mod 32. Higher data bits and carries are dropped.
- R9: `req_ready` is low from the cycle after a request is accepted until the result has been shown. `out_valid` is a single-cycle pulse.
- R10: After reset, `req_ready` is 1. `out_valid`, `rd_valid`, `remap_en`, `slot_sel` and every slot base are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Load a configuration (only while idle) |
| cfg_base | input | 4 | Encoded index-table base (halved register number) |
| cfg_mask | input | 5 | Operand remap enable mask |
| cfg_dim | input | 6 | Dimension size D |
| cfg_vl | input | 6 | Vector length used to derive Y |
| cfg_yx | input | 1 | 2D transposed walk enable |
| remap_en | output | 5 | Registered copy of the mask |
| slot_sel | output | 10 | Shape slot per operand, 2 bits each |
| slot_base | output | 20 | Table base per slot, 5 bits each |
| req_valid | input | 1 | Step request valid |
| req_ready | output | 1 | Block idle, request accepted |
| req_opnd | input | 3 | Operand number 0..4 |
| req_step | input | 6 | Loop element step |
| req_base | input | 5 | Operand base register |
| rd_valid | output | 1 | Register-file read request |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 5 | Register holding the index entry |
| rd_rvalid | input | 1 | Read data returned |
| rd_rdata | input | 64 | Index entry value |
| out_valid | output | 1 | Result pulse |
| out_reg | output | 5 | Remapped register number |

## Verification
A wrong stored dimension, Y size or table base shows up as a wrong `rd_addr` on the first read of the following step, one cycle after acceptance, with no further delay. A wrong mask or slot register shows up on `remap_en`, `slot_sel` or `slot_base` in the cycle right after the configuration. A state machine that loses its place shows up in two ways: a missing or stretched `out_valid` pulse, or a `req_ready` that rises early. This is visible within one cycle of the point where the step should have ended.

// File: rtl/idx_remap_pkg.sv
package idx_remap_pkg;
  localparam int unsigned NOPND  = 5;
  localparam int unsigned OPND_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_DONE
  } rmp_state_t;

  // number of set bits of m strictly below position k
  function automatic int unsigned ones_below(logic [NOPND-1:0] m, int unsigned k);
    int unsigned cnt;
    cnt = 0;
    for (int unsigned j = 0; j < NOPND; j++) begin
      if (j < k && m[j]) cnt = cnt + 1;
    end
    return cnt;
  endfunction
endpackage

// File: rtl/idx_remap_cfg.sv
module idx_remap_cfg
  import idx_remap_pkg::*;
#(
  parameter int unsigned REGW   = 5,
  parameter int unsigned STEP_W = 6,
  parameter int unsigned NSLOT  = 4,
  parameter int unsigned SLOT_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_valid,
  input  logic [REGW-2:0]         cfg_base,
  input  logic [NOPND-1:0]        cfg_mask,
  input  logic [STEP_W-1:0]       cfg_dim,
  input  logic [STEP_W-1:0]       cfg_vl,
  input  logic                    cfg_yx,
  output logic [NOPND-1:0]        mask_q,
  output logic [REGW-1:0]         tbase_q,
  output logic [STEP_W-1:0]       dim_q,
  output logic [STEP_W-1:0]       ydim_q,
  output logic                    yx_q,
  output logic [NOPND*SLOT_W-1:0] slot_sel,
  output logic [NSLOT*REGW-1:0]   slot_base
);
  logic [STEP_W-1:0] dim_d;
  logic [STEP_W-1:0] ydim_d;
  logic [REGW-1:0]   tbase_d;
  int unsigned       used_slots;

  // next-state: zero dimension folds to one, Y derived once here
  always_comb begin
    dim_d   = (cfg_dim == '0) ? STEP_W'(1) : cfg_dim;
    ydim_d  = cfg_vl / dim_d;
    tbase_d = {cfg_base, 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      tbase_q <= '0;
      dim_q   <= STEP_W'(1);
      ydim_q  <= '0;
      yx_q    <= 1'b0;
    end else if (cfg_valid) begin
      mask_q  <= cfg_mask;
      tbase_q <= tbase_d;
      dim_q   <= dim_d;
      ydim_q  <= ydim_d;
      yx_q    <= cfg_yx;
    end
  end

  assign used_slots = ones_below(mask_q, NOPND);

  for (genvar k = 0; k < NOPND; k++) begin : g_opnd
    assign slot_sel[k*SLOT_W +: SLOT_W] =
      mask_q[k] ? SLOT_W'(ones_below(mask_q, k)) : '0;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign slot_base[s*REGW +: REGW] = (s < used_slots) ? tbase_q : '0;
  end
endmodule

// File: rtl/idx_remap_addr.sv
module idx_remap_addr #(
  parameter int unsigned REGW   = 5,
  parameter int unsigned STEP_W = 6
) (
  input  logic [STEP_W-1:0] step,
  input  logic [STEP_W-1:0] dim,
  input  logic [STEP_W-1:0] ydim,
  input  logic              yx,
  input  logic [REGW-1:0]   tbase,
  output logic [REGW-1:0]   addr
);
  localparam int unsigned PW = 2 * STEP_W;

  logic [STEP_W-1:0] xi;
  logic [STEP_W-1:0] yi;
  logic [PW-1:0]     prod;
  logic [PW-1:0]     entry;
  logic              unused_entry_hi;

  always_comb begin
    xi    = step % dim;
    yi    = step / dim;
    prod  = {{STEP_W{1'b0}}, xi} * {{STEP_W{1'b0}}, ydim};
    entry = yx ? (prod + {{STEP_W{1'b0}}, yi}) : {{STEP_W{1'b0}}, xi};
    addr  = tbase + entry[REGW-1:0];
  end

  assign unused_entry_hi = ^entry[PW-1:REGW];
endmodule

// File: rtl/idx_remap_unit.sv
module idx_remap_unit
  import idx_remap_pkg::*;
#(
  parameter int unsigned REGW   = 5,
  parameter int unsigned STEP_W = 6,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned NSLOT  = 4,
  parameter int unsigned SLOT_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_valid,
  input  logic [REGW-2:0]         cfg_base,
  input  logic [NOPND-1:0]        cfg_mask,
  input  logic [STEP_W-1:0]       cfg_dim,
  input  logic [STEP_W-1:0]       cfg_vl,
  input  logic                    cfg_yx,
  output logic [NOPND-1:0]        remap_en,
  output logic [NOPND*SLOT_W-1:0] slot_sel,
  output logic [NSLOT*REGW-1:0]   slot_base,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [OPND_W-1:0]       req_opnd,
  input  logic [STEP_W-1:0]       req_step,
  input  logic [REGW-1:0]         req_base,
  output logic                    rd_valid,
  input  logic                    rd_ready,
  output logic [REGW-1:0]         rd_addr,
  input  logic                    rd_rvalid,
  input  logic [DATA_W-1:0]       rd_rdata,
  output logic                    out_valid,
  output logic [REGW-1:0]         out_reg
);
  logic [NOPND-1:0]  mask_q;
  logic [REGW-1:0]   tbase_q;
  logic [STEP_W-1:0] dim_q;
  logic [STEP_W-1:0] ydim_q;
  logic              yx_q;

  rmp_state_t        st_q, st_d;
  logic [STEP_W-1:0] step_q;
  logic [REGW-1:0]   base_q;
  logic [REGW-1:0]   res_q, res_d;
  logic              opnd_en;
  logic              acc_en;
  logic              res_en;
  logic              unused_rdata_hi;

  idx_remap_cfg #(
    .REGW(REGW), .STEP_W(STEP_W), .NSLOT(NSLOT), .SLOT_W(SLOT_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .cfg_base  (cfg_base),
    .cfg_mask  (cfg_mask),
    .cfg_dim   (cfg_dim),
    .cfg_vl    (cfg_vl),
    .cfg_yx    (cfg_yx),
    .mask_q    (mask_q),
    .tbase_q   (tbase_q),
    .dim_q     (dim_q),
    .ydim_q    (ydim_q),
    .yx_q      (yx_q),
    .slot_sel  (slot_sel),
    .slot_base (slot_base)
  );

  idx_remap_addr #(.REGW(REGW), .STEP_W(STEP_W)) u_addr (
    .step  (step_q),
    .dim   (dim_q),
    .ydim  (ydim_q),
    .yx    (yx_q),
    .tbase (tbase_q),
    .addr  (rd_addr)
  );

  // next-state and enables
  always_comb begin
    opnd_en = (32'(req_opnd) < NOPND) ? mask_q[req_opnd] : 1'b0;
    acc_en  = req_valid && (st_q == ST_IDLE);
    res_en  = (acc_en && !opnd_en) || ((st_q == ST_WAIT) && rd_rvalid);
    res_d   = (st_q == ST_WAIT) ? (base_q + rd_rdata[REGW-1:0])
                                : (req_base + req_step[REGW-1:0]);
    st_d    = st_q;
    case (st_q)
      ST_IDLE: if (req_valid) st_d = opnd_en ? ST_READ : ST_DONE;
      ST_READ: if (rd_ready)  st_d = ST_WAIT;
      ST_WAIT: if (rd_rvalid) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      base_q <= '0;
    end else if (acc_en) begin
      step_q <= req_step;
      base_q <= req_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  assign remap_en        = mask_q;
  assign req_ready       = (st_q == ST_IDLE);
  assign rd_valid        = (st_q == ST_READ);
  assign out_valid       = (st_q == ST_DONE);
  assign out_reg         = res_q;
  assign unused_rdata_hi = ^rd_rdata[DATA_W-1:REGW];
endmodule

// File: rtl/idx_remap_chk.sv
module idx_remap_chk #(
  parameter int unsigned REGW  = 5,
  parameter int unsigned NOPND = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_valid,
  input logic [REGW-2:0] cfg_base,
  input logic [NOPND-1:0] cfg_mask,
  input logic [NOPND-1:0] remap_en,
  input logic [REGW-1:0] slot_base0,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rd_valid,
  input logic            rd_ready,
  input logic [REGW-1:0] rd_addr,
  input logic            rd_rvalid,
  input logic            out_valid
);
  assert_mask_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> remap_en == $past(cfg_mask));

  assert_slot0_base_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_mask != '0) |=> slot_base0 == {$past(cfg_base), 1'b0});

  assert_read_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  assert_result_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(rd_rvalid || (req_valid && req_ready)));

  assert_out_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind idx_remap_unit idx_remap_chk #(.REGW(REGW), .NOPND(5)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_valid  (cfg_valid),
  .cfg_base   (cfg_base),
  .cfg_mask   (cfg_mask),
  .remap_en   (remap_en),
  .slot_base0 (slot_base[REGW-1:0]),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_addr    (rd_addr),
  .rd_rvalid  (rd_rvalid),
  .out_valid  (out_valid)
);

// File: tb/idx_remap_unit_bench.sv
`timescale 1ns/1ps
module idx_remap_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [3:0]  cfg_base = '0;
  logic [4:0]  cfg_mask = '0;
  logic [5:0]  cfg_dim = '0;
  logic [5:0]  cfg_vl = '0;
  logic        cfg_yx = 1'b0;
  logic [4:0]  remap_en;
  logic [9:0]  slot_sel;
  logic [19:0] slot_base;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_opnd = '0;
  logic [5:0]  req_step = '0;
  logic [4:0]  req_base = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [4:0]  rd_addr;
  logic        rd_rvalid = 1'b0;
  logic [63:0] rd_rdata = '0;
  logic        out_valid;
  logic [4:0]  out_reg;

  int checks = 0;
  int fails  = 0;
  logic [63:0] rf [32];

  always #2.5 clk = ~clk;

  idx_remap_unit u_idx_remap_unit (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_base(cfg_base),
    .cfg_mask(cfg_mask), .cfg_dim(cfg_dim), .cfg_vl(cfg_vl), .cfg_yx(cfg_yx),
    .remap_en(remap_en), .slot_sel(slot_sel), .slot_base(slot_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_opnd(req_opnd),
    .req_step(req_step), .req_base(req_base), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_rvalid(rd_rvalid),
    .rd_rdata(rd_rdata), .out_valid(out_valid), .out_reg(out_reg)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic configure(input int fld, input int msk, input int d,
                           input int vl, input bit yx);
    int nset;
    @(negedge clk);
    cfg_valid = 1'b1; cfg_base = 4'(fld); cfg_mask = 5'(msk);
    cfg_dim = 6'(d); cfg_vl = 6'(vl); cfg_yx = yx;
    @(negedge clk);
    cfg_valid = 1'b0;
    chk(remap_en == 5'(msk), "R2 mask copy", 64'(remap_en), 64'(msk));
    nset = 0;
    for (int k = 0; k < 5; k++) begin
      int exp_slot;
      exp_slot = msk[k] ? nset : 0;
      if (msk[k]) nset++;
      chk(slot_sel[2*k +: 2] == 2'(exp_slot), "R3 slot select",
          64'(slot_sel[2*k +: 2]), 64'(exp_slot));
    end
    for (int s = 0; s < 4; s++) begin
      int exp_b;
      exp_b = (s < nset) ? 2*fld : 0;
      chk(slot_base[5*s +: 5] == 5'(exp_b), "R1 slot base",
          64'(slot_base[5*s +: 5]), 64'(exp_b));
    end
  endtask

  task automatic run_step(input int fld, input int msk, input int d,
                          input int vl, input bit yx, input int op,
                          input int st, input int bs);
    int de, yd, ent, ea, er;
    string tag;
    de  = (d == 0) ? 1 : d;
    yd  = vl / de;
    ent = yx ? ((st / de) + (st % de) * yd) : (st % de);
    ea  = (2*fld + ent) % 32;
    tag = (d == 0) ? "R6 zero dim address" : (yx ? "R5 2D address" : "R4 1D address");
    @(negedge clk);
    req_valid = 1'b1; req_opnd = 3'(op); req_step = 6'(st); req_base = 5'(bs);
    @(negedge clk);
    req_valid = 1'b0;
    if (msk[op]) begin
      chk(rd_valid && rd_addr == 5'(ea), tag, 64'(rd_addr), 64'(ea));
      chk(!req_ready, "R9 busy", 64'(req_ready), 64'd0);
      for (int w = 0; w < st % 3; w++) @(negedge clk);
      chk(rd_valid && rd_addr == 5'(ea), "R8 read held", 64'(rd_addr), 64'(ea));
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
      for (int w = 0; w < op % 2; w++) @(negedge clk);
      chk(!out_valid && !rd_valid, "R8 no early result", 64'(out_valid), 64'd0);
      rd_rvalid = 1'b1; rd_rdata = rf[ea];
      @(negedge clk);
      rd_rvalid = 1'b0; rd_rdata = '0;
      er = (bs + int'(rf[ea] % 32)) % 32;
      chk(out_valid && out_reg == 5'(er), "R8 remapped result", 64'(out_reg), 64'(er));
    end else begin
      er = (bs + st) % 32;
      chk(out_valid && !rd_valid && out_reg == 5'(er), "R7 sequential result",
          64'(out_reg), 64'(er));
    end
    @(negedge clk);
    chk(!out_valid && req_ready, "R9 single pulse", 64'(out_valid), 64'd0);
  endtask

  initial begin
    for (int k = 0; k < 32; k++)
      rf[k] = 64'hC0DE_0000_0000_0000 | (64'(k) << 40) | 64'((k*13 + 5) % 64);
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int flds [3];
    int msks [3];
    int dims [6];
    flds = '{8, 1, 13};
    msks = '{5'b00001, 5'b01111, 5'b10110};
    dims = '{0, 1, 2, 3, 4, 6};
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(req_ready && !out_valid && !rd_valid, "R10 reset handshake",
        {61'd0, req_ready, out_valid, rd_valid}, 64'd4);
    chk(remap_en == '0 && slot_sel == '0 && slot_base == '0, "R10 reset config",
        64'(slot_base), 64'd0);
    rst_n = 1'b1;
    for (int m = 0; m < 3; m++)
      for (int di = 0; di < 6; di++)
        for (int y = 0; y < 2; y++) begin
          configure(flds[m], msks[m], dims[di], 6, y[0]);
          for (int st = 0; st < 6; st++)
            for (int op = 0; op < 5; op++)
              run_step(flds[m], msks[m], dims[di], 6, y[0], op, st, (op*5 + 3 + st) % 32);
        end
    // D equals VL: table walked in order
    configure(8, 5'b00001, 6, 6, 1'b0);
    for (int st = 0; st < 6; st++) run_step(8, 5'b00001, 6, 6, 1'b0, 0, st, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule